// File: doc/BRIEF.md
# Guarded vector-base control register

This block is an 8-bit control register that the core addresses like memory. It sets where the interrupt vector table is based: at the start of program memory or at the start of the boot section. The select bit that chooses the base is protected. To change it, software first arms a change-enable bit. Then, while the hardware keeps that enable alive for a fixed number of cycles, software writes the new select value with the enable position cleared. Any other attempt to change the select bit leaves it unchanged.

Arming the enable also blanks interrupt delivery. The blanking lasts while the enable is alive. After a protected write, it lasts until the first instruction retires after the write cycle. The blanking only gates the request vector that leaves the block. The global enable input is never modified. A second mode bit lets only the SPI-related request lines through and treats every other line as if global interrupts were off. The three upper bits are plain storage for a neighbouring port block.

Top module: `vsel_ctrl_reg`

## Requirements
- R1: After a synchronous reset, `ctrl_q`, `rd_data` and `vec_boot` are 0, and `irq_out` is 0.
- R2: A write with `wr_en`=1 and `wr_addr`=REG_ADDR (default 0x0E) updates bits 7:5 and bit 2 from `wr_data`. Bits 4:3 always read 0. `rd_data` shows the register one cycle after `rd_addr` selects REG_ADDR, and shows 0 for any other address.
- R3: A register write with bit 0 = 1 sets the change-enable bit (`ctrl_q[0]`) from the next cycle. Hardware clears it after exactly UNLOCK_CYCLES (default 4) cycles if no protected write occurs.
- R4: A protected write is a register write with bit 0 = 0 while `ctrl_q[0]`=1. It loads `wr_data[1]` into the select bit (`ctrl_q[1]`) and clears `ctrl_q[0]` in the next cycle. This also holds in the last cycle of the window.
- R5: A write to bit 1 does not change the select bit if the change-enable bit is 0, or if the same write has bit 0 = 1. The other writable bits in that write are still updated.
- R6: `vec_boot` equals the select bit: 0 selects the program-memory base and 1 selects the boot-section base.
- R7: While `ctrl_q[0]`=1, `irq_out` is all zeros. After a protected write, `irq_out` stays zero until the cycle after the first `retire` pulse that comes in a cycle after the write cycle. A `retire` pulse during the write cycle itself does not end the blanking.
- R8: If no protected write occurs, blanking ends in the same cycle that the change-enable bit expires.
- R9: With no blanking and with `ctrl_q[2]`=0, `irq_out` equals `irq_req` when `gie`=1 and is 0 when `gie`=0.
- R10: While `ctrl_q[2]`=1, only the request lines set in SPI_MASK (default lines 2:0) can reach `irq_out`, and only when `gie`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| irq_req | input | NUM_IRQ | Per-source interrupt requests |
| gie | input | 1 | Global interrupt enable flag (only read) |
| retire | input | 1 | Instruction-retire strobe |
| ctrl_q | output | 8 | Live register value |
| vec_boot | output | 1 | Vector base select (1 = boot section) |
| irq_out | output | NUM_IRQ | Gated interrupt requests |

## Verification
The bench builds the block with its default parameters: eight request lines, the SPI group on lines 2:0, a four-cycle unlock window and the register at address 0x0E. Because the window is only four cycles long, the bench can reach every window position directly. It checks a protected write in the last live cycle, a write one cycle after expiry, and arming and selecting in the same write. It drives a mixed request pattern such as 0xA5, so each line of the SPI group and each line outside it is seen on its own.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int CE_POS  = 0;
  localparam int SEL_POS = 1;
  localparam int SPI_POS = 2;
  localparam int PORT_LO = 5;
  localparam int PORT_HI = 7;
  localparam int REG_W   = 8;
endpackage

// File: rtl/vsel_unlock.sv
module vsel_unlock #(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic commit,
  input  logic retire,
  output logic ce,
  output logic hold
);
  localparam int CNT_W = $clog2(UNLOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic             pend;

  // change-enable lifetime counter
  always_ff @(posedge clk) begin
    if (rst) begin
      ce  <= 1'b0;
      cnt <= '0;
    end else if (arm) begin
      ce  <= 1'b1;
      cnt <= CNT_W'(UNLOCK_CYCLES);
    end else if (commit) begin
      ce  <= 1'b0;
      cnt <= '0;
    end else if (ce) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) ce <= 1'b0;
    end
  end

  // blanking held after a protected write until an instruction retires
  always_ff @(posedge clk) begin
    if (rst)         pend <= 1'b0;
    else if (commit) pend <= 1'b1;
    else if (retire) pend <= 1'b0;
  end

  assign hold = ce | pend;
endmodule

// File: rtl/vsel_irq_gate.sv
module vsel_irq_gate #(
  parameter int             NUM_IRQ  = 8,
  parameter logic [NUM_IRQ-1:0] SPI_MASK = NUM_IRQ'(3'b111)
) (
  input  logic [NUM_IRQ-1:0] req,
  input  logic               gie,
  input  logic               spi_only,
  input  logic               blank,
  output logic [NUM_IRQ-1:0] gated
);
  logic [NUM_IRQ-1:0] allow;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      if (SPI_MASK[i]) begin : g_spi
        assign allow[i] = gie;
      end else begin : g_other
        assign allow[i] = gie & ~spi_only;
      end
    end
  endgenerate

  assign gated = blank ? '0 : (req & allow);
endmodule

// File: rtl/vsel_ctrl_reg.sv
module vsel_ctrl_reg #(
  parameter int                 ADDR_W        = 6,
  parameter logic [ADDR_W-1:0]  REG_ADDR      = ADDR_W'(14),
  parameter int                 NUM_IRQ       = 8,
  parameter logic [NUM_IRQ-1:0] SPI_MASK      = NUM_IRQ'(3'b111),
  parameter int                 UNLOCK_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               gie,
  input  logic               retire,
  output logic [7:0]         ctrl_q,
  output logic               vec_boot,
  output logic [NUM_IRQ-1:0] irq_out
);
  import vsel_pkg::*;

  localparam int PORT_W = PORT_HI - PORT_LO + 1;

  logic              hit, arm, commit, ce, hold;
  logic              sel_q, spi_q;
  logic [PORT_W-1:0] port_q;

  assign hit    = wr_en && (wr_addr == REG_ADDR);
  assign arm    = hit &&  wr_data[CE_POS];
  assign commit = hit && !wr_data[CE_POS] && ce;

  vsel_unlock #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_unlock (
    .clk(clk), .rst(rst), .arm(arm), .commit(commit),
    .retire(retire), .ce(ce), .hold(hold)
  );

  // plain storage bits
  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= '0;
      spi_q  <= 1'b0;
    end else if (hit) begin
      port_q <= wr_data[PORT_HI:PORT_LO];
      spi_q  <= wr_data[SPI_POS];
    end
  end

  // protected select bit
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 1'b0;
    else if (commit) sel_q <= wr_data[SEL_POS];
  end

  always_comb begin
    ctrl_q                  = '0;
    ctrl_q[PORT_HI:PORT_LO] = port_q;
    ctrl_q[SPI_POS]         = spi_q;
    ctrl_q[SEL_POS]         = sel_q;
    ctrl_q[CE_POS]          = ce;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_addr == REG_ADDR) ? ctrl_q : '0;
  end

  assign vec_boot = sel_q;

  vsel_irq_gate #(.NUM_IRQ(NUM_IRQ), .SPI_MASK(SPI_MASK)) u_gate (
    .req(irq_req), .gie(gie), .spi_only(spi_q),
    .blank(hold), .gated(irq_out)
  );
endmodule

// File: rtl/vsel_ctrl_reg_chk.sv
module vsel_ctrl_reg_chk #(
  parameter int                 ADDR_W        = 6,
  parameter logic [ADDR_W-1:0]  REG_ADDR      = ADDR_W'(14),
  parameter int                 NUM_IRQ       = 8,
  parameter logic [NUM_IRQ-1:0] SPI_MASK      = NUM_IRQ'(3'b111),
  parameter int                 UNLOCK_CYCLES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [7:0]         wr_data,
  input logic [7:0]         ctrl_q,
  input logic               vec_boot,
  input logic               gie,
  input logic [NUM_IRQ-1:0] irq_out
);
  int run;
  always_ff @(posedge clk) begin
    if (rst)            run <= 0;
    else if (ctrl_q[0]) run <= run + 1;
    else                run <= 0;
  end

  a_r3_ce_bounded: assert property (@(posedge clk) disable iff (rst)
    run <= UNLOCK_CYCLES);

  a_r4_commit_loads: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_ADDR && !wr_data[0] && ctrl_q[0])
    |=> (!ctrl_q[0] && vec_boot == $past(wr_data[1])));

  a_r5_sel_guarded: assert property (@(posedge clk) disable iff (rst)
    !$stable(vec_boot)
    |-> $past(wr_en && wr_addr == REG_ADDR && !wr_data[0] && ctrl_q[0]));

  a_r7_blank_while_ce: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[0] |-> (irq_out == '0));

  a_r9_gie_off: assert property (@(posedge clk) disable iff (rst)
    !gie |-> (irq_out == '0));

  a_r10_spi_only: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[2] |-> ((irq_out & ~SPI_MASK) == '0));

  a_r2_dead_bits: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[4:3] == 2'b00);
endmodule

bind vsel_ctrl_reg vsel_ctrl_reg_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .NUM_IRQ(NUM_IRQ),
  .SPI_MASK(SPI_MASK), .UNLOCK_CYCLES(UNLOCK_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ctrl_q(ctrl_q), .vec_boot(vec_boot),
  .gie(gie), .irq_out(irq_out)
);

// File: tb/sim_vsel_ctrl_reg.sv
module sim_vsel_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] RA = 6'h0E;

  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0, gie = 1'b0, retire = 1'b0;
  logic [5:0] wr_addr = RA, rd_addr = '0;
  logic [7:0] wr_data = '0, irq_req = '0;
  logic [7:0] rd_data, ctrl_q, irq_out;
  logic       vec_boot;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vsel_ctrl_reg u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_req(irq_req), .gie(gie), .retire(retire), .ctrl_q(ctrl_q),
    .vec_boot(vec_boot), .irq_out(irq_out)
  );

  // {write data, irq_req, gie, expected irq_out, expected ctrl_q}
  localparam logic [32:0] VEC [6] = '{
    {8'h00, 8'hFF, 1'b1, 8'hFF, 8'h00},
    {8'h04, 8'hFF, 1'b1, 8'h07, 8'h04},
    {8'hFC, 8'hA5, 1'b1, 8'h05, 8'hE4},
    {8'hE0, 8'hA5, 1'b1, 8'hA5, 8'hE0},
    {8'hE2, 8'h3C, 1'b0, 8'h00, 8'hE0},
    {8'h00, 8'h3C, 1'b1, 8'h3C, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic ret);
    wr_en = 1'b1; wr_data = d; retire = ret;
    @(negedge clk);
    wr_en = 1'b0; retire = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_retire();
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk("R1 ctrl", 32'(ctrl_q), 0);
    chk("R1 vec_boot", 32'(vec_boot), 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    chk("R1 rd_data", 32'(rd_data), 0);

    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][32:25], 1'b0);
      irq_req = VEC[k][24:17];
      gie     = VEC[k][16];
      #1;
      chk("R2/R5 table ctrl", 32'(ctrl_q), 32'(VEC[k][7:0]));
      chk("R9/R10 table irq", 32'(irq_out), 32'(VEC[k][15:8]));
      chk("R6 table vec_boot", 32'(vec_boot), 0);
    end

    // R2 read path
    wr(8'hE4, 1'b0);
    rd_addr = RA; @(negedge clk);
    chk("R2 read hit", 32'(rd_data), 32'hE4);
    rd_addr = 6'h00; @(negedge clk);
    chk("R2 read miss", 32'(rd_data), 0);
    wr(8'h00, 1'b0);

    // R3/R8 window expiry with blanking
    gie = 1'b1; irq_req = 8'hFF;
    wr(8'h01, 1'b0);
    for (int c = 0; c < 4; c++) begin
      chk("R3 ce alive", 32'(ctrl_q[0]), 1);
      chk("R7 blank while ce", 32'(irq_out), 0);
      @(negedge clk);
    end
    chk("R3 ce expired", 32'(ctrl_q[0]), 0);
    chk("R8 blank ends", 32'(irq_out), 32'hFF);
    chk("R6 base unchanged", 32'(vec_boot), 0);

    // R4/R7 protected write, retire in write cycle ignored
    wr(8'h01, 1'b0);
    wr(8'h06, 1'b1);
    chk("R4 commit ctrl", 32'(ctrl_q), 32'h06);
    chk("R6 boot base", 32'(vec_boot), 1);
    chk("R7 held after commit", 32'(irq_out), 0);
    idle(2);
    chk("R7 held no retire", 32'(irq_out), 0);
    pulse_retire();
    chk("R7 released / R10", 32'(irq_out), 32'h07);

    // R4 commit in last window cycle
    wr(8'h01, 1'b0);
    idle(3);
    wr(8'h00, 1'b0);
    chk("R4 last-cycle commit", 32'(vec_boot), 0);
    chk("R4 ce cleared", 32'(ctrl_q), 0);
    pulse_retire();
    chk("R7 release", 32'(irq_out), 32'hFF);

    // R5 write one cycle after expiry
    wr(8'h01, 1'b0);
    idle(4);
    wr(8'h02, 1'b0);
    chk("R5 late write", 32'(vec_boot), 0);
    chk("R5 late ctrl", 32'(ctrl_q), 0);
    chk("R8 no hold", 32'(irq_out), 32'hFF);

    // R5 arm and select together
    wr(8'h03, 1'b0);
    chk("R5 same-write sel", 32'(vec_boot), 0);
    chk("R3 armed", 32'(ctrl_q), 32'h01);
    idle(4);
    chk("R3 expired again", 32'(ctrl_q), 0);

    // R9 gie off
    gie = 1'b0; #1;
    chk("R9 gie off", 32'(irq_out), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule